// File: doc/BRIEF.md
# Wide Send Residue Merger

This block sits on the sending side of a 16-bit data path. It takes a byte stream read from memory and packs it into two-byte bus words. Each move command gives a start pulse, a byte count and a chained flag. The byte count is the number of bytes the block reads from memory. It is not the number of bytes that leave on the bus.

A chained command can end on an odd byte. In that case the block does not send the byte as a half-empty word. It keeps the byte in a residue register and raises a held flag. The next command that reads at least one byte puts the kept byte in the low lane and its own first byte in the high lane, and sends the two as one full word. A command without the chained flag sends a trailing odd byte as a final partial word. The high lane of that word is zero and only the low-lane valid bit is set.

The memory side and the bus side each use a valid/ready handshake. A one-cycle done pulse closes each command.

Top module: `wide_tx_packer`

## Requirements
- R1: Each full bus word carries the earlier memory byte in bits 7:0 and the later byte in bits 15:8, with `bus_lane_vld` = 2'b11. While `bus_valid` is high, `bus_lane_vld[0]` is always 1.
- R2: On a chained command with an odd number of bytes left to pair, the last memory byte does not appear on the bus. `res_held` rises in the cycle that byte is taken, and that is the cycle in which `cmd_done` pulses.
- R3: When `res_held` is set, the next command with a non-zero count sends the held byte in bits 7:0 and its own first memory byte in bits 15:8 as its first word. `res_held` falls only when that word is accepted by the bus side.
- R4: On a command without the chained flag that ends on an unpaired byte, the last word has that byte in bits 7:0, zero in bits 15:8, and `bus_lane_vld` = 2'b01.
- R5: A command with count N takes exactly N bytes from memory. `mem_ready` is low once N bytes have been taken.
- R6: `cmd_done` is a single-cycle pulse. It is high in the first cycle in which all N bytes have been taken, every word has been accepted and no word is pending. A count of zero gives the pulse in the cycle right after the start.
- R7: A word offered with `bus_ready` low stays unchanged until it is accepted. No memory byte is taken while a word is waiting.
- R8: A `cmd_start` pulse while a command is running is ignored. The running command keeps its own count and chained flag.
- R9: Reset empties the residue register and clears `res_held`, `bus_valid`, `mem_ready` and `cmd_done`. After reset no merge takes place.
- R10: A command with count zero leaves a held residue byte and `res_held` unchanged, for a later command to merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Start pulse for a move command, accepted only when idle |
| cmd_count | input | CNT_W | Number of bytes to read from memory |
| cmd_chain | input | 1 | Chained flag: an unpaired last byte is kept, not sent |
| mem_data | input | BYTE_W | Memory byte |
| mem_valid | input | 1 | Memory byte is valid |
| mem_ready | output | 1 | Block takes a memory byte |
| bus_data | output | 2*BYTE_W | Bus word, earlier byte in the low lane |
| bus_lane_vld | output | 2 | Valid bit per lane, bit 0 = low lane |
| bus_valid | output | 1 | Bus word is offered |
| bus_ready | input | 1 | Bus side accepts the word |
| cmd_done | output | 1 | One-cycle end-of-command pulse |
| res_held | output | 1 | A residue byte is held for the next command |

## Verification
Two events can meet near the end of a command: the bus side accepting the last word, and the completion decision. The bus stalls are arranged so that the last word is accepted only a few cycles after the last byte was taken. The done pulse is then checked on every clock against a model condition: all bytes taken, expected-word queue empty, nothing offered. The pulse must not come early, while the word is still offered, and it must not come late. A second overlap is the start of a command while a residue byte is held. The first word must then combine two commands' bytes, and the held flag must fall only when that word is accepted. The model decides both points from its own queue of pending words.

// File: rtl/wtp_pkg.sv
package wtp_pkg;

   typedef enum logic [0:0] {
      WTP_IDLE = 1'b0,
      WTP_RUN  = 1'b1
   } wtp_state_e;

   localparam int WTP_LANES = 2;

   typedef logic [WTP_LANES-1:0] wtp_lane_mask_t;

   localparam wtp_lane_mask_t WTP_MASK_FULL = 2'b11;
   localparam wtp_lane_mask_t WTP_MASK_LOW  = 2'b01;

endpackage

// File: rtl/wtp_remaining.sv
module wtp_remaining #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] rem_o,
   output logic             last_o,
   output logic             empty_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (load_i) begin
         rem_q <= load_val_i;
      end else if (dec_i && (rem_q != '0)) begin
         rem_q <= rem_q - ONE;
      end
   end

   assign rem_o   = rem_q;
   assign last_o  = (rem_q == ONE);
   assign empty_o = (rem_q == '0);

endmodule

// File: rtl/wtp_residue.sv
module wtp_residue #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [BYTE_W-1:0] cap_byte_i,
   input  logic              release_i,
   output logic              held_o,
   output logic [BYTE_W-1:0] byte_o
);

   logic              held_q;
   logic [BYTE_W-1:0] byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         byte_q <= '0;
      end else begin
         if (capture_i) begin
            held_q <= 1'b1;
            byte_q <= cap_byte_i;
         end else if (release_i) begin
            held_q <= 1'b0;
            byte_q <= '0;
         end
      end
   end

   assign held_o = held_q;
   assign byte_o = byte_q;

endmodule

// File: rtl/wtp_assemble.sv
module wtp_assemble
   import wtp_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        seed_i,
   input  logic [BYTE_W-1:0]           seed_byte_i,
   input  logic                        take_i,
   input  logic [BYTE_W-1:0]           take_byte_i,
   input  logic                        take_last_i,
   input  logic                        chain_i,
   input  logic                        bus_ready_i,
   output logic                        slot_busy_o,
   output logic                        word_full_o,
   output logic [WTP_LANES*BYTE_W-1:0] word_o,
   output wtp_lane_mask_t              lanes_o,
   output logic                        park_o,
   output logic                        res_sent_o
);

   logic [BYTE_W-1:0] slot_q;
   logic              slot_vld_q;
   logic              slot_res_q;
   logic [BYTE_W-1:0] lane_q [WTP_LANES];
   wtp_lane_mask_t    mask_q;
   logic              full_q;
   logic              has_res_q;

   logic pair_now;
   logic tail_send;
   logic tail_keep;
   logic fill_slot;
   logic drain;

   assign drain     = full_q && bus_ready_i;
   assign pair_now  = take_i && slot_vld_q;
   assign tail_keep = take_i && !slot_vld_q && take_last_i && chain_i;
   assign tail_send = take_i && !slot_vld_q && take_last_i && !chain_i;
   assign fill_slot = take_i && !slot_vld_q && !take_last_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q     <= '0;
         slot_vld_q <= 1'b0;
         slot_res_q <= 1'b0;
      end else if (seed_i) begin
         slot_q     <= seed_byte_i;
         slot_vld_q <= 1'b1;
         slot_res_q <= 1'b1;
      end else if (pair_now) begin
         slot_vld_q <= 1'b0;
         slot_res_q <= 1'b0;
      end else if (fill_slot) begin
         slot_q     <= take_byte_i;
         slot_vld_q <= 1'b1;
         slot_res_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q    <= 1'b0;
         mask_q    <= '0;
         has_res_q <= 1'b0;
         for (int i = 0; i < WTP_LANES; i++) begin
            lane_q[i] <= '0;
         end
      end else if (pair_now) begin
         full_q    <= 1'b1;
         mask_q    <= WTP_MASK_FULL;
         has_res_q <= slot_res_q;
         lane_q[0] <= slot_q;
         lane_q[1] <= take_byte_i;
      end else if (tail_send) begin
         full_q    <= 1'b1;
         mask_q    <= WTP_MASK_LOW;
         has_res_q <= 1'b0;
         lane_q[0] <= take_byte_i;
         lane_q[1] <= '0;
      end else if (drain) begin
         full_q    <= 1'b0;
         has_res_q <= 1'b0;
      end
   end

   for (genvar g = 0; g < WTP_LANES; g++) begin : g_lane
      assign word_o[g*BYTE_W +: BYTE_W] = full_q ? lane_q[g] : '0;
   end

   assign lanes_o     = full_q ? mask_q : '0;
   assign word_full_o = full_q;
   assign slot_busy_o = slot_vld_q;
   assign park_o      = tail_keep;
   assign res_sent_o  = drain && has_res_q;

endmodule

// File: rtl/wide_tx_packer.sv
module wide_tx_packer
   import wtp_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_start,
   input  logic [CNT_W-1:0]            cmd_count,
   input  logic                        cmd_chain,
   input  logic [BYTE_W-1:0]           mem_data,
   input  logic                        mem_valid,
   output logic                        mem_ready,
   output logic [WTP_LANES*BYTE_W-1:0] bus_data,
   output logic [WTP_LANES-1:0]        bus_lane_vld,
   output logic                        bus_valid,
   input  logic                        bus_ready,
   output logic                        cmd_done,
   output logic                        res_held
);

   if (BYTE_W < 1) begin : g_bad_byte_w
      $error("wide_tx_packer: BYTE_W must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("wide_tx_packer: CNT_W must be at least 1");
   end

   wtp_state_e state_q;
   logic       chain_q;

   logic             start_ok;
   logic             take;
   logic             seed;
   logic [CNT_W-1:0] rem;
   logic             rem_last;
   logic             rem_empty;
   logic             slot_busy;
   logic             word_full;
   logic             park;
   logic             res_sent;
   logic [BYTE_W-1:0] res_byte;
   wtp_lane_mask_t   lanes;

   assign start_ok = (state_q == WTP_IDLE) && cmd_start;
   assign seed     = start_ok && res_held && (cmd_count != '0);
   assign mem_ready = (state_q == WTP_RUN) && !rem_empty && !word_full;
   assign take      = mem_valid && mem_ready;
   assign cmd_done  = (state_q == WTP_RUN) && rem_empty && !slot_busy && !word_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WTP_IDLE;
         chain_q <= 1'b0;
      end else begin
         case (state_q)
            WTP_IDLE: begin
               if (cmd_start) begin
                  state_q <= WTP_RUN;
                  chain_q <= cmd_chain;
               end
            end
            WTP_RUN: begin
               if (cmd_done) begin
                  state_q <= WTP_IDLE;
               end
            end
            default: state_q <= WTP_IDLE;
         endcase
      end
   end

   wtp_remaining #(
      .CNT_W(CNT_W)
   ) u_rem (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_ok),
      .load_val_i (cmd_count),
      .dec_i      (take),
      .rem_o      (rem),
      .last_o     (rem_last),
      .empty_o    (rem_empty)
   );

   wtp_residue #(
      .BYTE_W(BYTE_W)
   ) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_i  (park),
      .cap_byte_i (mem_data),
      .release_i  (res_sent),
      .held_o     (res_held),
      .byte_o     (res_byte)
   );

   wtp_assemble #(
      .BYTE_W(BYTE_W)
   ) u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .seed_i      (seed),
      .seed_byte_i (res_byte),
      .take_i      (take),
      .take_byte_i (mem_data),
      .take_last_i (rem_last),
      .chain_i     (chain_q),
      .bus_ready_i (bus_ready),
      .slot_busy_o (slot_busy),
      .word_full_o (word_full),
      .word_o      (bus_data),
      .lanes_o     (lanes),
      .park_o      (park),
      .res_sent_o  (res_sent)
   );

   assign bus_lane_vld = lanes;
   assign bus_valid    = word_full;

   logic unused_rem;
   assign unused_rem = ^rem;

endmodule

// File: rtl/wtp_checker.sv
module wtp_checker #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mem_ready,
   input logic [2*BYTE_W-1:0] bus_data,
   input logic [1:0]          bus_lane_vld,
   input logic                bus_valid,
   input logic                bus_ready,
   input logic                cmd_done,
   input logic                res_held
);

   AST_LOW_LANE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> bus_lane_vld[0]); // R1

   AST_PARTIAL_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_lane_vld[1]) |-> (bus_data[2*BYTE_W-1:BYTE_W] == '0)); // R4

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data) && $stable(bus_lane_vld))); // R7

   AST_NO_FETCH_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !mem_ready); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done); // R6

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> (!bus_valid && !mem_ready)); // R6

   AST_HELD_SET_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_held) |-> cmd_done); // R2

   AST_HELD_CLEAR_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(res_held) |-> $past(bus_valid && bus_ready)); // R3

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |-> (!res_held && !bus_valid && !mem_ready && !cmd_done)); // R9

endmodule

bind wide_tx_packer wtp_checker #(
   .BYTE_W(BYTE_W)
) u_wtp_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .mem_ready    (mem_ready),
   .bus_data     (bus_data),
   .bus_lane_vld (bus_lane_vld),
   .bus_valid    (bus_valid),
   .bus_ready    (bus_ready),
   .cmd_done     (cmd_done),
   .res_held     (res_held)
);

// File: tb/wide_tx_packer_test.sv
module wide_tx_packer_test;

   localparam int CLK_PERIOD = 10;
   localparam int BW         = 8;
   localparam int CW         = 16;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_start = 1'b0;
   logic [CW-1:0] cmd_count = '0;
   logic          cmd_chain = 1'b0;
   logic [BW-1:0] mem_data = '0;
   logic          mem_valid = 1'b0;
   logic          mem_ready;
   logic [2*BW-1:0] bus_data;
   logic [1:0]    bus_lane_vld;
   logic          bus_valid;
   logic          bus_ready = 1'b0;
   logic          cmd_done;
   logic          res_held;

   int checks = 0;
   int fails  = 0;

   bit            model_held = 1'b0;
   logic [BW-1:0] model_byte = '0;
   logic [17:0]   exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   wide_tx_packer #(.BYTE_W(BW), .CNT_W(CW)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_start    (cmd_start),
      .cmd_count    (cmd_count),
      .cmd_chain    (cmd_chain),
      .mem_data     (mem_data),
      .mem_valid    (mem_valid),
      .mem_ready    (mem_ready),
      .bus_data     (bus_data),
      .bus_lane_vld (bus_lane_vld),
      .bus_valid    (bus_valid),
      .bus_ready    (bus_ready),
      .cmd_done     (cmd_done),
      .res_held     (res_held)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0;
      @(negedge clk);
      chk(!res_held, "R9", "res_held in reset", res_held, 0);
      chk(!bus_valid, "R9", "bus_valid in reset", bus_valid, 0);
      chk(!mem_ready, "R9", "mem_ready in reset", mem_ready, 0);
      chk(!cmd_done, "R9", "cmd_done in reset", cmd_done, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      model_held = 1'b0;
      exp_q.delete();
   endtask

   // Runs one command; mode picks the stall pattern, poke sends a stray start.
   task automatic run_cmd(input int cnt, input bit chain, input int seed,
                          input int mode, input bit poke);
      logic [BW-1:0] bytes[$];
      logic [BW-1:0] seq[$];
      int idx = 0;
      int cyc = 0;
      bit done_seen = 1'b0;
      bit expect_done;
      logic [17:0] w;
      for (int i = 0; i < cnt; i++) bytes.push_back(BW'(seed + i * 17));
      if (cnt > 0) begin
         if (model_held) seq.push_back(model_byte);
         model_held = 1'b0;
         foreach (bytes[i]) seq.push_back(bytes[i]);
         while (seq.size() >= 2) begin
            logic [BW-1:0] lo = seq.pop_front();
            logic [BW-1:0] hi = seq.pop_front();
            exp_q.push_back({2'b11, hi, lo});
         end
         if (seq.size() == 1) begin
            if (chain) begin
               model_held = 1'b1;
               model_byte = seq[0];
            end else begin
               exp_q.push_back({2'b01, 8'h00, seq[0]});
            end
         end
      end
      @(posedge clk); #1;
      cmd_start = 1'b1;
      cmd_count = CW'(cnt);
      cmd_chain = chain;
      @(posedge clk); #1;
      cmd_start = 1'b0;
      cmd_chain = ~chain;
      while (!done_seen) begin
         mem_valid = (idx < cnt) && ((mode == 0) || (((cyc * 7 + 3) % 5) != 0));
         mem_data  = (idx < cnt) ? bytes[idx] : 8'hEE;
         case (mode)
            0: bus_ready = 1'b1;
            1: bus_ready = ((cyc * 3 + 1) % 4) != 0;
            default: bus_ready = (cyc >= 6) && ((cyc % 3) != 1);
         endcase
         cmd_start = poke && (cyc == 2);
         cmd_count = CW'(cnt + 5);
         @(negedge clk);
         expect_done = (idx == cnt) && (exp_q.size() == 0) && !bus_valid;
         chk(cmd_done == expect_done, "R6", "done timing", cmd_done, expect_done);
         if (bus_valid) begin
            chk(bus_lane_vld[0], "R1", "low lane valid", bus_lane_vld, 2'b01);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected bus word", bus_data, 0);
            end else if (bus_ready) begin
               w = exp_q.pop_front();
               chk({bus_lane_vld, bus_data} == w, "R1", "bus word", {bus_lane_vld, bus_data}, w);
            end
         end
         if (mem_ready) chk(idx < cnt, "R5", "mem_ready after count", idx, cnt);
         if (mem_valid && mem_ready) idx++;
         if (cmd_done) begin
            chk(res_held == model_held, "R3", "held flag at done", res_held, model_held);
            done_seen = 1'b1;
         end
         @(posedge clk); #1;
         cyc++;
      end
      mem_valid = 1'b0;
      cmd_start = 1'b0;
      bus_ready = 1'b0;
      @(negedge clk);
      chk(!bus_valid && !mem_ready, "R5", "quiet after done", {bus_valid, mem_ready}, 0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", WATCHDOG, WATCHDOG);
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      chk(!res_held && !bus_valid && !mem_ready && !cmd_done, "R9", "reset state",
          {res_held, bus_valid, mem_ready, cmd_done}, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      run_cmd(8, 1'b0, 8'h10, 0, 1'b0);   // R1 R5 even, free flow
      run_cmd(5, 1'b0, 8'h20, 2, 1'b0);   // R4 R7 partial tail under stall
      run_cmd(7, 1'b1, 8'h30, 1, 1'b0);   // R2 chained odd keeps last byte
      run_cmd(0, 1'b0, 8'h00, 0, 1'b0);   // R10 R6 zero count keeps residue
      chk(res_held, "R10", "residue after zero count", res_held, 1);
      run_cmd(4, 1'b0, 8'h40, 2, 1'b0);   // R3 merge then partial tail
      run_cmd(3, 1'b1, 8'h50, 1, 1'b1);   // R8 stray start ignored, R2
      run_cmd(1, 1'b1, 8'h60, 2, 1'b0);   // R3 merge with single byte
      run_cmd(1, 1'b1, 8'h70, 0, 1'b0);   // R2 single byte kept
      do_reset();                         // R9 residue dropped
      run_cmd(2, 1'b0, 8'h80, 1, 1'b0);   // R9 no merge after reset
      run_cmd(40, 1'b1, 8'h90, 1, 1'b1);  // R5 R8 long even chained
      run_cmd(9, 1'b1, 8'hA0, 2, 1'b0);   // R2 held at end
      run_cmd(6, 1'b1, 8'hB0, 1, 1'b0);   // R3 merge, odd again kept
      run_cmd(0, 1'b1, 8'h00, 2, 1'b0);   // R10 chained zero count
      run_cmd(3, 1'b0, 8'hC0, 2, 1'b0);   // R3 merge, even finish
      summary();
      $finish;
   end

endmodule